// File: doc/BRIEF.md
# SRAM Byte Write Control

This block sits between the pins of a 36-bit synchronous SRAM and its storage array. The word is four 9-bit lanes, each of 8 data bits and 1 parity bit. Each cycle the block reads the write-control inputs. When the address stage reports the chip selected, those inputs decide which lanes the array writes on the next cycle. The block registers the write data so that it lines up with those lane strobes. It also carries the read data from the array through a pipelined output stage, and it decides when the data pins may drive.

Writes follow a three-level order. A low global write enable writes every lane, whatever the byte enables say. If the global write enable is high, a byte-write gate decides whether the four per-lane byte enables are looked at at all. If the gate is high, no write takes place. Whenever a write strobe is active, the output drivers turn off. Otherwise they drive only when the asynchronous output enable is low and the read in the output stage belongs to a selected cycle.

The control inputs are sampled together with the address. The array returns read data one cycle after the address is loaded. The block adds two read stages, so read data reaches the pins two cycles after the address load.

Top module: `sbw_ctrl_top`

## Requirements
- R1: While reset is held, and until the first control cycle after release, `lane_we`, `wr_mask`, `wdata_q`, `dq_oe` and `dq_out` are all zero.
- R2: If `sel` is 1 and `gwe_n` is 0 at a rising edge, `lane_we` is 4'b1111 after that edge, whatever `bgate_n` and `ben_n` hold.
- R3: If `sel` is 1, `gwe_n` is 1 and `bgate_n` is 0 at a rising edge, `lane_we[i]` after that edge is the inverse of `ben_n[i]`.
- R4: If `gwe_n` and `bgate_n` are both 1 at a rising edge, `lane_we` is 0 after that edge, whatever `ben_n` holds.
- R5: If `sel` is 0 at a rising edge, `lane_we` is 0 after that edge, even when `gwe_n` is 0.
- R6: Lane i covers data bits 8i to 8i+7 of `wr_mask` and parity bit 32+i. Every bit in that set equals `lane_we[i]`.
- R7: `wdata_q` holds the `wdata` value sampled at the most recent rising edge.
- R8: `rdata_in` sampled at edge k appears on `dq_out` after edge k+1. This is two cycles after the address load that produced it.
- R9: `dq_oe` is 1 only if three things hold at once: `oe_n` is 0, the read now in the output stage came from a cycle with `sel` at 1, and `lane_we` is zero. `oe_n` acts on `dq_oe` without waiting for a clock edge.
- R10: `dq_out` is all zero whenever `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gwe_n | input | 1 | Global write enable, active low, writes all lanes |
| bgate_n | input | 1 | Byte-write gate, active low, lets `ben_n` through |
| ben_n | input | 4 | Per-lane byte enables, active low |
| sel | input | 1 | Chip-selected result from the address stage, active high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 36 | Write data, bits 31:0 data, 35:32 parity |
| rdata_in | input | 36 | Read data from the array, one cycle after address load |
| lane_we | output | 4 | Registered lane write strobes |
| wr_mask | output | 36 | Bit-level write mask expanded from the strobes |
| wdata_q | output | 36 | Registered write data aligned with the strobes |
| dq_out | output | 36 | Pipelined read data, zero while not driving |
| dq_oe | output | 1 | Data pin output-driver enable |

## Verification
The bench sets `gwe_n` low while `bgate_n` and `ben_n` are held high. A design that lets the gate outrank the global write would write nothing in that case. It also drives every byte enable low while the gate is high; a leaky gate would write all four lanes. It issues a global write while the chip is deselected, where a missing select term would corrupt the array. Single-lane patterns walk across the lanes to catch a parity bit routed to the wrong lane.

On the read side, reads go out back to back and expected data is compared two cycles after each address load. A stage too few or too many would show up as data shifted by one word. A write that lands between reads must drop `dq_oe`. `oe_n` is also toggled in the middle of a cycle, so a design that registers it would lag by one cycle.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

  localparam int unsigned SBW_LANES     = 4;
  localparam int unsigned SBW_LANE_DATA = 8;
  localparam int unsigned SBW_RD_STAGES = 2;

  // Which level of the write hierarchy produced this cycle's strobes.
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_GLOBAL = 2'd1,
    SRC_BYTE   = 2'd2
  } wr_src_e;

endpackage

// File: rtl/sbw_rst_sync.sv
module sbw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/sbw_strobe_dec.sv
module sbw_strobe_dec
  import sbw_pkg::*;
#(
  parameter int unsigned LANES = SBW_LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gwe_n,
  input  logic             bgate_n,
  input  logic [LANES-1:0] ben_n,
  input  logic             sel,
  output logic [LANES-1:0] lane_we
);

  wr_src_e          src;
  logic [LANES-1:0] lane_we_d;

  // Next-state: global write outranks the gated byte enables.
  always_comb begin
    if (!sel)          src = SRC_NONE;
    else if (!gwe_n)   src = SRC_GLOBAL;
    else if (!bgate_n) src = SRC_BYTE;
    else               src = SRC_NONE;
  end

  always_comb begin
    unique case (src)
      SRC_GLOBAL: lane_we_d = '1;
      SRC_BYTE:   lane_we_d = ~ben_n;
      default:    lane_we_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lane_we <= '0;
    else        lane_we <= lane_we_d;
  end

  // R2
  a_r2_global_all: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !gwe_n) |=> (lane_we == {LANES{1'b1}}));
  // R3
  a_r3_gated_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && gwe_n && !bgate_n) |=> (lane_we == ~$past(ben_n)));
  // R4
  a_r4_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (gwe_n && bgate_n) |=> (lane_we == '0));
  // R5
  a_r5_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel) |=> (lane_we == '0));

endmodule

// File: rtl/sbw_wdata_reg.sv
module sbw_wdata_reg #(
  parameter int unsigned WIDTH = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] wdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wdata_q <= '0;
    else        wdata_q <= wdata;
  end

  // R7
  a_r7_wdata_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wdata_q == $past(wdata)));

endmodule

// File: rtl/sbw_rd_pipe.sv
module sbw_rd_pipe #(
  parameter int unsigned WIDTH  = 36,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic [WIDTH-1:0] rdata_in,
  output logic             rd_sel,
  output logic [WIDTH-1:0] rd_data
);

  // sel_q[0] lines up with the array access; the rest follow the data stages.
  logic             sel_q  [STAGES+1];
  logic [WIDTH-1:0] data_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q[0] <= 1'b0;
    else        sel_q[0] <= sel;
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q[s+1] <= 1'b0;
        data_q[s]  <= '0;
      end else begin
        sel_q[s+1] <= sel_q[s];
        data_q[s]  <= (s == 0) ? rdata_in : data_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign rd_sel  = sel_q[STAGES];
  assign rd_data = data_q[STAGES-1];

  // R8 (first stage captures array data)
  a_r8_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (data_q[0] == $past(rdata_in)));

endmodule

// File: rtl/sbw_drv_ctl.sv
module sbw_drv_ctl #(
  parameter int unsigned LANES = 4,
  parameter int unsigned WIDTH = 36
) (
  input  logic             oe_n,
  input  logic             rd_sel,
  input  logic [LANES-1:0] lane_we,
  input  logic [WIDTH-1:0] rd_data,
  output logic             dq_oe,
  output logic [WIDTH-1:0] dq_out
);

  logic wr_active;

  always_comb begin
    wr_active = |lane_we;
    dq_oe     = !oe_n && rd_sel && !wr_active;
    dq_out    = dq_oe ? rd_data : '0;
  end

endmodule

// File: rtl/sbw_ctrl_top.sv
module sbw_ctrl_top
  import sbw_pkg::*;
#(
  parameter int unsigned LANES     = SBW_LANES,
  parameter int unsigned LANE_DATA = SBW_LANE_DATA,
  parameter int unsigned RD_STAGES = SBW_RD_STAGES,
  localparam int unsigned DATA_W   = LANES * LANE_DATA,
  localparam int unsigned WORD_W   = DATA_W + LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gwe_n,
  input  logic              bgate_n,
  input  logic [LANES-1:0]  ben_n,
  input  logic              sel,
  input  logic              oe_n,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] rdata_in,
  output logic [LANES-1:0]  lane_we,
  output logic [WORD_W-1:0] wr_mask,
  output logic [WORD_W-1:0] wdata_q,
  output logic [WORD_W-1:0] dq_out,
  output logic              dq_oe
);

  logic              rst_sn;
  logic              rd_sel;
  logic [WORD_W-1:0] rd_data;

  sbw_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  sbw_strobe_dec #(.LANES(LANES)) u_dec (
    .clk     (clk),
    .rst_n   (rst_sn),
    .gwe_n   (gwe_n),
    .bgate_n (bgate_n),
    .ben_n   (ben_n),
    .sel     (sel),
    .lane_we (lane_we)
  );

  sbw_wdata_reg #(.WIDTH(WORD_W)) u_wreg (
    .clk     (clk),
    .rst_n   (rst_sn),
    .wdata   (wdata),
    .wdata_q (wdata_q)
  );

  sbw_rd_pipe #(.WIDTH(WORD_W), .STAGES(RD_STAGES)) u_rd (
    .clk      (clk),
    .rst_n    (rst_sn),
    .sel      (sel),
    .rdata_in (rdata_in),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data)
  );

  sbw_drv_ctl #(.LANES(LANES), .WIDTH(WORD_W)) u_drv (
    .oe_n    (oe_n),
    .rd_sel  (rd_sel),
    .lane_we (lane_we),
    .rd_data (rd_data),
    .dq_oe   (dq_oe),
    .dq_out  (dq_out)
  );

  // Lane i: data byte i in the low field, parity bit i in the top field.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign wr_mask[i*LANE_DATA +: LANE_DATA] = {LANE_DATA{lane_we[i]}};
    assign wr_mask[DATA_W + i]               = lane_we[i];

    // R6
    a_r6_lane_parity: assert property (@(posedge clk) disable iff (!rst_sn)
      wr_mask[DATA_W + i] == wr_mask[i*LANE_DATA]);
  end

  // R9
  a_r9_write_kills_drive: assert property (@(posedge clk) disable iff (!rst_sn)
    (|lane_we) |-> !dq_oe);
  // R9
  a_r9_needs_select: assert property (@(posedge clk) disable iff (!rst_sn)
    dq_oe |-> (!oe_n && rd_sel));
  // R10
  a_r10_quiet_pins: assert property (@(posedge clk) disable iff (!rst_sn)
    !dq_oe |-> (dq_out == '0));

endmodule

// File: tb/sbw_ctrl_top_tb.sv
`timescale 1ns/1ps
module sbw_ctrl_top_tb_top;

  typedef struct packed {
    logic        gwe_n;
    logic        bgate_n;
    logic [3:0]  ben_n;
    logic        sel;
    logic [5:0]  addr;
    logic [35:0] wdata;
  } stim_t;

  logic        clk;
  logic        rst_n;
  logic        oe_n;
  stim_t       cur;
  logic [5:0]  addr_q;
  logic [35:0] rdata_in;
  logic [3:0]  lane_we;
  logic [35:0] wr_mask, wdata_q, dq_out;
  logic        dq_oe;

  int    n_chk;
  int    n_fail;
  bit    checking;
  bit    done;
  stim_t hist [3];

  sbw_ctrl_top dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .gwe_n    (cur.gwe_n),
    .bgate_n  (cur.bgate_n),
    .ben_n    (cur.ben_n),
    .sel      (cur.sel),
    .oe_n     (oe_n),
    .wdata    (cur.wdata),
    .rdata_in (rdata_in),
    .lane_we  (lane_we),
    .wr_mask  (wr_mask),
    .wdata_q  (wdata_q),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Array model: address register, read data one cycle after load.
  function automatic logic [35:0] pat(logic [5:0] a);
    return {a[3:0] ^ 4'hA, 32'h1357_9BDF ^ {4{2'b01, a}}};
  endfunction

  always_ff @(posedge clk) addr_q <= cur.addr;
  assign rdata_in = pat(addr_q);

  function automatic logic [3:0] exp_we(stim_t s);
    if (!s.sel)          return 4'h0;
    else if (!s.gwe_n)   return 4'hF;
    else if (!s.bgate_n) return ~s.ben_n;
    else                 return 4'h0;
  endfunction

  function automatic logic [35:0] exp_mask(logic [3:0] w);
    logic [35:0] m = '0;
    for (int i = 0; i < 4; i++) begin
      m[i*8 +: 8] = {8{w[i]}};
      m[32+i]     = w[i];
    end
    return m;
  endfunction

  function automatic string we_tag(stim_t s);
    if (!s.sel)          return "R5";
    else if (!s.gwe_n)   return "R2";
    else if (!s.bgate_n) return "R3";
    else                 return "R4";
  endfunction

  task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic check_regs();
    logic [3:0] w;
    logic       oe_exp;
    w      = exp_we(hist[0]);
    oe_exp = !oe_n && hist[2].sel && (w == 4'h0);
    chk(we_tag(hist[0]), {32'h0, lane_we}, {32'h0, w});
    chk("R6", wr_mask, exp_mask(w));
    chk("R7", wdata_q, hist[0].wdata);
    chk("R9", {35'h0, dq_oe}, {35'h0, oe_exp});
    if (oe_exp) chk("R8", dq_out, pat(hist[2].addr));
    else        chk("R10", dq_out, 36'h0);
  endtask

  task automatic cycle(stim_t s, logic oe);
    logic oe_exp;
    @(negedge clk);
    if (checking) check_regs();
    cur  = s;
    oe_n = oe;
    #1;
    if (checking) begin
      // R9: output enable takes effect without a clock edge.
      oe_exp = !oe && hist[2].sel && (exp_we(hist[0]) == 4'h0);
      chk("R9", {35'h0, dq_oe}, {35'h0, oe_exp});
    end
    hist[2] = hist[1];
    hist[1] = hist[0];
    hist[0] = s;
  endtask

  function automatic stim_t idle_stim();
    stim_t s;
    s.gwe_n = 1'b1; s.bgate_n = 1'b1; s.ben_n = 4'hF;
    s.sel = 1'b0; s.addr = '0; s.wdata = '0;
    return s;
  endfunction

  function automatic stim_t rd_stim(logic [5:0] a);
    stim_t s = idle_stim();
    s.sel = 1'b1; s.addr = a; s.wdata = {30'h0, a};
    return s;
  endfunction

  function automatic stim_t rand_stim();
    stim_t       s;
    logic [63:0] r;
    r         = {$urandom, $urandom};
    s.sel     = ($urandom % 4) != 0;
    s.gwe_n   = ($urandom % 4) != 0;
    s.bgate_n = ($urandom % 2) != 0;
    s.ben_n   = 4'($urandom);
    s.addr    = 6'($urandom);
    s.wdata   = r[35:0];
    return s;
  endfunction

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    stim_t s;
    void'($urandom(32'h5B3C_11D7));
    n_chk = 0; n_fail = 0; checking = 1'b0; done = 1'b0;
    cur = idle_stim(); oe_n = 1'b0; rst_n = 1'b0;
    for (int i = 0; i < 3; i++) hist[i] = idle_stim();

    // R1: reset state, with inputs requesting a write and a drive.
    s = rd_stim(6'h3); s.gwe_n = 1'b0; s.wdata = 36'hF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    cur = s;
    repeat (3) @(negedge clk);
    chk("R1", {32'h0, lane_we}, 36'h0);
    chk("R1", wr_mask, 36'h0);
    chk("R1", wdata_q, 36'h0);
    chk("R1", {35'h0, dq_oe}, 36'h0);
    chk("R1", dq_out, 36'h0);
    cur = idle_stim();
    rst_n = 1'b1;
    repeat (6) cycle(idle_stim(), 1'b0);
    checking = 1'b1;

    // R2: global write overrides a closed gate and idle byte enables.
    s = rd_stim(6'h01); s.gwe_n = 1'b0; s.bgate_n = 1'b1; s.ben_n = 4'hF;
    cycle(s, 1'b0);
    // R4: gate high blocks every byte enable.
    s = rd_stim(6'h02); s.bgate_n = 1'b1; s.ben_n = 4'h0;
    cycle(s, 1'b0);
    // R5: deselected global write does nothing.
    s = idle_stim(); s.gwe_n = 1'b0; s.bgate_n = 1'b0; s.ben_n = 4'h0;
    cycle(s, 1'b0);
    // R3 / R6: walk single lanes and pairs.
    for (int i = 0; i < 4; i++) begin
      s = rd_stim(6'(i + 8)); s.bgate_n = 1'b0; s.ben_n = ~(4'h1 << i);
      cycle(s, 1'b0);
    end
    s = rd_stim(6'h0C); s.bgate_n = 1'b0; s.ben_n = 4'b1010;
    cycle(s, 1'b0);
    // R8: back-to-back reads, then a write inside the stream (R9).
    for (int i = 0; i < 6; i++) cycle(rd_stim(6'(i * 7 + 1)), 1'b0);
    s = rd_stim(6'h20); s.gwe_n = 1'b0;
    cycle(s, 1'b0);
    for (int i = 0; i < 4; i++) cycle(rd_stim(6'(i + 40)), 1'b0);
    // R9: output enable toggled each cycle during reads.
    for (int i = 0; i < 6; i++) cycle(rd_stim(6'(i + 50)), 1'(i % 2));
    repeat (3) cycle(idle_stim(), 1'b0);

    // Random mix of all patterns.
    for (int i = 0; i < 2000; i++) cycle(rand_stim(), 1'(($urandom % 3) == 0));
    cycle(idle_stim(), 1'b0);
    summary();
  end

endmodule